// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous 32K x 8 static RAM. The host issues one word at a time through a valid/ready handshake, carrying a 15-bit address, a direction flag and, for writes, a data byte. The controller turns each request into a strobe sequence on the memory pins: active-low chip select, write enable and output enable. It also produces a data-out bus with a separate drive enable, which an outer pad ring resolves into the shared I/O pins, and samples the memory's data-in bus for reads.

Every memory timing figure is a parameter in nanoseconds. The figures are write pulse width, chip-select-to-end-of-write, address-valid-to-end-of-write, data setup, write cycle, address access, output-enable access, read cycle and output turn-off. Each figure is rounded up to whole clock cycles. This lets one netlist serve faster or slower memory grades by changing parameters only.

Read results come back on a read data bus together with a one-cycle valid pulse. The host may present a new request as soon as ready returns.

Top module: `asyncSramCtrl`

## Requirements
- R1: After reset and whenever the controller is idle, chip select, write enable and output enable are high, the data drive enable is low, and ready is high.
- R2: A write spends exactly one setup cycle with the new address and all strobes high. When no turnaround wait applies, it then holds chip select and write enable low together for exactly PULSE cycles. PULSE is the largest of the rounded write-pulse, chip-select, address-valid and data-setup times, and at least 1. Output enable stays high throughout, and the data drive enable is high only while write enable is low.
- R3: The memory address changes only on the edge that accepts a request, when all strobes are high. It stays stable for the whole cycle that follows.
- R4: A write that is not delayed by turnaround occupies 1 + PULSE + WREC cycles from the accepting edge until ready returns. WREC is the rounded write-cycle time minus (PULSE + 1) when that difference is positive, and 1 otherwise.
- R5: A read keeps write enable high and holds chip select and output enable low for exactly ACC cycles. ACC is the larger of the rounded address-access and output-enable-access times, and at least 1. The data-in bus is sampled on the edge that raises the strobes. The captured byte appears on the read data bus with a one-cycle valid pulse 1 + ACC edges after acceptance.
- R6: A read occupies 1 + ACC + RREC cycles until ready returns. RREC is the rounded read-cycle time minus (ACC + 1) when that is positive, and 1 otherwise.
- R7: The data drive enable never rises fewer than TURN cycles after output enable last rose. TURN is the rounded output turn-off time, at least 1. A write accepted one idle cycle after a read's recovery therefore lengthens its setup phase to max(1, TURN - RREC - 1) cycles.
- R8: Ready is low from the accepting edge until recovery completes. Request valid, address and data presented while ready is low are ignored: the write lands at, and the read returns from, the address latched at acceptance.
- R9: Nanosecond figures are converted by rounding up, so with a 4 ns clock and the default figures PULSE=14, WREC=3, ACC=18, RREC=1 and TURN=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address of the request |
| reqWdata | input | DATA_W | Byte to write |
| reqReady | output | 1 | Controller can accept a request |
| rdData | output | DATA_W | Last byte read from memory |
| rdValid | output | 1 | One-cycle pulse: rdData is new |
| memAddr | output | ADDR_W | Address to the memory |
| memCsN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDout | output | DATA_W | Data toward the memory pins |
| memDoutEn | output | 1 | Drive enable for memDout |
| memDin | input | DATA_W | Data sampled from the memory pins |

## Verification
The bench pairs the controller with a memory model. The model returns a poison byte until the output-enable window has lasted the full access count, so a controller that samples one cycle early reads garbage instead of the stored byte. The model keeps driving for the turn-off interval after a read, so a write that starts its drive one cycle too soon after a read is flagged as bus contention. The model also measures every write and read strobe window exactly, and it watches for an address change during the write overlap. Scrambling the request inputs while the controller is busy exposes a design that re-latches its address or data mid-cycle: the sweep's read-back then fails.

// File: rtl/asyncSramPkg.sv
package asyncSramPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC,
    ST_RSETUP,
    ST_RACC,
    ST_RREC
  } seqStateT;

  // Control to datapath: what the pins must look like after the next edge
  typedef struct packed {
    logic load;      // latch the host request
    logic selOn;     // chip select asserted
    logic wrOn;      // write enable asserted
    logic rdOn;      // output enable asserted
    logic driveOn;   // controller drives the data pins
    logic capture;   // sample memory data on this edge
  } strobeT;

  function automatic int unsigned nsToCyc(int unsigned ns, int unsigned clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int unsigned maxU(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asyncSramSeq.sv
module asyncSramSeq
  import asyncSramPkg::*;
#(
  parameter int unsigned PULSE_CYC = 14,
  parameter int unsigned WREC_CYC  = 3,
  parameter int unsigned ACC_CYC   = 18,
  parameter int unsigned RREC_CYC  = 1,
  parameter int unsigned TURN_CYC  = 8,
  parameter int unsigned CNT_W     = 5
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output strobeT strobeNext
);

  seqStateT         state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [CNT_W-1:0] turnCnt, turnNext;
  logic             cntDone;
  logic             turnDone;

  assign cntDone  = (cnt == '0);
  assign turnDone = (turnCnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNext  = state;
    cntNext    = cntDone ? cnt : cnt - 1'b1;
    strobeNext = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobeNext.load = 1'b1;
          stateNext       = reqWrite ? ST_WSETUP : ST_RSETUP;
        end
      end
      ST_WSETUP: begin
        // setup phase doubles as the bus-turnaround wait
        if (turnDone) begin
          stateNext = ST_WPULSE;
          cntNext   = CNT_W'(PULSE_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (cntDone) begin
          stateNext = ST_WREC;
          cntNext   = CNT_W'(WREC_CYC - 1);
        end
      end
      ST_WREC: begin
        if (cntDone) stateNext = ST_IDLE;
      end
      ST_RSETUP: begin
        stateNext = ST_RACC;
        cntNext   = CNT_W'(ACC_CYC - 1);
      end
      ST_RACC: begin
        if (cntDone) begin
          stateNext          = ST_RREC;
          cntNext            = CNT_W'(RREC_CYC - 1);
          strobeNext.capture = 1'b1;
        end
      end
      ST_RREC: begin
        if (cntDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    strobeNext.selOn   = (stateNext == ST_WPULSE) || (stateNext == ST_RACC);
    strobeNext.wrOn    = (stateNext == ST_WPULSE);
    strobeNext.rdOn    = (stateNext == ST_RACC);
    strobeNext.driveOn = (stateNext == ST_WPULSE);
  end

  always_comb begin
    if (state == ST_RACC && cntDone)
      turnNext = CNT_W'(TURN_CYC - 1);
    else if (!turnDone)
      turnNext = turnCnt - 1'b1;
    else
      turnNext = turnCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      turnCnt <= '0;
    end else begin
      state   <= stateNext;
      cnt     <= cntNext;
      turnCnt <= turnNext;
    end
  end

endmodule

// File: rtl/asyncSramDatapath.sv
module asyncSramDatapath
  import asyncSramPkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobeNext,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      memDout   <= '0;
      memCsN    <= 1'b1;
      memWeN    <= 1'b1;
      memOeN    <= 1'b1;
      memDoutEn <= 1'b0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      if (strobeNext.load) begin
        memAddr <= reqAddr;
        memDout <= reqWdata;
      end
      memCsN    <= !strobeNext.selOn;
      memWeN    <= !strobeNext.wrOn;
      memOeN    <= !strobeNext.rdOn;
      memDoutEn <= strobeNext.driveOn;
      rdValid   <= strobeNext.capture;
      if (strobeNext.capture) rdData <= memDin;
    end
  end

endmodule

// File: rtl/asyncSramCtrl.sv
module asyncSramCtrl
  import asyncSramPkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 4,
  parameter int unsigned T_WP_NS = 55,
  parameter int unsigned T_CW_NS = 50,
  parameter int unsigned T_AW_NS = 50,
  parameter int unsigned T_DW_NS = 30,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_OE_NS = 35,
  parameter int unsigned T_RC_NS = 70,
  parameter int unsigned T_HZ_NS = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  localparam int unsigned WR_PULSE_CYC = maxU(1, maxU(maxU(nsToCyc(T_WP_NS, CLK_NS), nsToCyc(T_CW_NS, CLK_NS)),
                                                      maxU(nsToCyc(T_AW_NS, CLK_NS), nsToCyc(T_DW_NS, CLK_NS))));
  localparam int unsigned WC_CYC       = nsToCyc(T_WC_NS, CLK_NS);
  localparam int unsigned WR_REC_CYC   = (WC_CYC > WR_PULSE_CYC + 1) ? WC_CYC - WR_PULSE_CYC - 1 : 1;
  localparam int unsigned RD_ACC_CYC   = maxU(1, maxU(nsToCyc(T_AA_NS, CLK_NS), nsToCyc(T_OE_NS, CLK_NS)));
  localparam int unsigned RC_CYC       = nsToCyc(T_RC_NS, CLK_NS);
  localparam int unsigned RD_REC_CYC   = (RC_CYC > RD_ACC_CYC + 1) ? RC_CYC - RD_ACC_CYC - 1 : 1;
  localparam int unsigned TURN_CYC     = maxU(1, nsToCyc(T_HZ_NS, CLK_NS));
  localparam int unsigned MAX_CYC      = maxU(maxU(WR_PULSE_CYC, WR_REC_CYC),
                                              maxU(maxU(RD_ACC_CYC, RD_REC_CYC), TURN_CYC));
  localparam int unsigned CNT_W        = $clog2(MAX_CYC + 1);

  strobeT strobeNext;

  asyncSramSeq #(
    .PULSE_CYC(WR_PULSE_CYC),
    .WREC_CYC (WR_REC_CYC),
    .ACC_CYC  (RD_ACC_CYC),
    .RREC_CYC (RD_REC_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqReady  (reqReady),
    .strobeNext(strobeNext)
  );

  asyncSramDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobeNext(strobeNext),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .memDin    (memDin),
    .memAddr   (memAddr),
    .memCsN    (memCsN),
    .memWeN    (memWeN),
    .memOeN    (memOeN),
    .memDout   (memDout),
    .memDoutEn (memDoutEn),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: rtl/asyncSramCtrlChecker.sv
module asyncSramCtrlChecker #(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned WR_PULSE_CYC = 14,
  parameter int unsigned RD_ACC_CYC   = 18,
  parameter int unsigned TURN_CYC     = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCsN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDoutEn
);

  logic [15:0] weLowCnt, oeLowCnt, sinceOeHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt    <= '0;
      oeLowCnt    <= '0;
      sinceOeHigh <= 16'hFFFF;
    end else begin
      weLowCnt    <= !memWeN ? ((weLowCnt == 16'hFFFF) ? weLowCnt : weLowCnt + 1'b1) : '0;
      oeLowCnt    <= !memOeN ? ((oeLowCnt == 16'hFFFF) ? oeLowCnt : oeLowCnt + 1'b1) : '0;
      sinceOeHigh <= !memOeN ? '0 : ((sinceOeHigh == 16'hFFFF) ? sinceOeHigh : sinceOeHigh + 1'b1);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN && memWeN && memOeN && !memDoutEn));

  assert_write_overlap_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && memOeN));

  assert_drive_in_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> !memWeN);

  assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= 16'(WR_PULSE_CYC)));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(memAddr));

  assert_access_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeLowCnt >= 16'(RD_ACC_CYC)));

  assert_valid_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (memOeN && $past(!memOeN)));

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDoutEn) |-> (sinceOeHigh >= 16'(TURN_CYC - 1)));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> !reqReady);

endmodule

bind asyncSramCtrl asyncSramCtrlChecker #(
  .ADDR_W      (ADDR_W),
  .WR_PULSE_CYC(WR_PULSE_CYC),
  .RD_ACC_CYC  (RD_ACC_CYC),
  .TURN_CYC    (TURN_CYC)
) u_check (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rdValid  (rdValid),
  .memAddr  (memAddr),
  .memCsN   (memCsN),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memDoutEn(memDoutEn)
);

// File: tb/test_asyncSramCtrl.sv
`timescale 1ns/1ps
module test_asyncSramCtrl;

  localparam int CLK_NS = 4;
  function automatic int cdiv(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // expected cycle counts derived from the requirements (R9)
  localparam int E_PULSE = mx(1, mx(mx(cdiv(55), cdiv(50)), mx(cdiv(50), cdiv(30))));
  localparam int E_WREC  = (cdiv(70) > E_PULSE + 1) ? cdiv(70) - E_PULSE - 1 : 1;
  localparam int E_ACC   = mx(1, mx(cdiv(70), cdiv(35)));
  localparam int E_RREC  = (cdiv(70) > E_ACC + 1) ? cdiv(70) - E_ACC - 1 : 1;
  localparam int E_TURN  = mx(1, cdiv(30));
  localparam int E_WR_TOTAL = 1 + E_PULSE + E_WREC;
  localparam int E_RD_TOTAL = 1 + E_ACC + E_RREC;
  localparam int E_TURN_SETUP = mx(1, E_TURN - E_RREC - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic reqReady, rdValid, memCsN, memWeN, memOeN, memDoutEn;
  logic [7:0] rdData, memDout, memDin;
  logic [14:0] memAddr;

  always #2 clk = ~clk;

  asyncSramCtrl #(
    .ADDR_W(15), .DATA_W(8), .CLK_NS(CLK_NS),
    .T_WP_NS(55), .T_CW_NS(50), .T_AW_NS(50), .T_DW_NS(30), .T_WC_NS(70),
    .T_AA_NS(70), .T_OE_NS(35), .T_RC_NS(70), .T_HZ_NS(30)
  ) i_asyncSramCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rdData(rdData), .rdValid(rdValid), .memAddr(memAddr), .memCsN(memCsN),
    .memWeN(memWeN), .memOeN(memOeN), .memDout(memDout), .memDoutEn(memDoutEn),
    .memDin(memDin)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic tally(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0]  mem [64];
  logic [14:0] tagMem [64];
  bit          prevWr = 1'b0;
  logic [14:0] prevAddr = '0;
  logic [7:0]  prevData = '0;
  int weLow = 0, oeLow = 0, tail = 0;

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'h00;
      tagMem[i] = 15'h7FFF;
    end
  end

  always_comb begin
    if (oeLow >= E_ACC && tagMem[memAddr[5:0]] == memAddr) memDin = mem[memAddr[5:0]];
    else memDin = 8'hEE;
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit wrAct, rdAct;
      wrAct = !memCsN && !memWeN;
      rdAct = !memCsN && memWeN && !memOeN;
      if (memDoutEn && tail > 0) tally(1'b0, "R7", "bus contention, model tail", tail, 0);
      if (memDoutEn && memWeN) tally(1'b0, "R2", "drive while write enable high", 1, 0);
      if (prevWr && wrAct && memAddr != prevAddr) tally(1'b0, "R3", "address moved in write overlap", memAddr, prevAddr);
      if (prevWr && !wrAct) begin
        mem[prevAddr[5:0]] = prevData;
        tagMem[prevAddr[5:0]] = prevAddr;
      end
      if (wrAct) begin
        weLow++;
        prevData = memDoutEn ? memDout : 8'hDD;
      end else if (weLow > 0) begin
        tally(weLow == E_PULSE, "R2", "write pulse cycles", weLow, E_PULSE);
        weLow = 0;
      end
      prevWr = wrAct;
      prevAddr = memAddr;
      if (rdAct) begin
        oeLow++;
        tail = E_TURN;
      end else begin
        if (oeLow > 0) tally(oeLow == E_ACC, "R5", "read access cycles", oeLow, E_ACC);
        oeLow = 0;
        if (tail > 0) tail--;
      end
    end
  end

  // ---------------- host tasks (entered and left at a negedge) ----------------
  task automatic doWrite(logic [14:0] a, logic [7:0] d, int expLat, string req);
    int n;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    // R8: scrambled inputs while busy must be ignored
    reqWrite = 1'b0; reqAddr = ~a; reqWdata = ~d;
    n = 1;
    while (!reqReady && n < 1000) begin
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    tally(n - 1 == expLat, req, "write occupancy cycles", n - 1, expLat);
  endtask

  task automatic doRead(logic [14:0] a, logic [7:0] expData);
    int n, vAt;
    logic [7:0] got;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqWrite = 1'b1; reqAddr = ~a; reqWdata = 8'h5A;
    n = 1; vAt = -1; got = 8'h00;
    while (!reqReady && n < 1000) begin
      if (rdValid) begin vAt = n; got = rdData; end
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    tally(vAt - 1 == 1 + E_ACC, "R5", "rdValid edge after accept", vAt - 1, 1 + E_ACC);
    tally(got == expData, "R8", "read data at latched address", got, expData);
    tally(n - 1 == E_RD_TOTAL, "R6", "read occupancy cycles", n - 1, E_RD_TOTAL);
  endtask

  function automatic logic [14:0] addrOf(int i);
    return {9'((i * 37 + 5) % 512), 6'(i)};
  endfunction
  function automatic logic [7:0] dataOf(int i, int salt);
    return 8'((i * 29 + 3 + salt * 71) % 256);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset/idle state
    tally(memCsN && memWeN && memOeN, "R1", "strobes high at idle", {memCsN, memWeN, memOeN}, 7);
    tally(!memDoutEn, "R1", "drive off at idle", memDoutEn, 0);
    tally(reqReady, "R1", "ready at idle", reqReady, 1);
    tally(!rdValid, "R1", "no read valid at idle", rdValid, 0);
    // R9 rounding of default figures
    tally(E_PULSE == 14 && E_WREC == 3 && E_ACC == 18 && E_RREC == 1 && E_TURN == 8,
          "R9", "rounded cycle set", E_PULSE, 14);
    // sweep: write every slot, R4 occupancy
    for (int i = 0; i < 64; i++) doWrite(addrOf(i), dataOf(i, 0), E_WR_TOTAL, "R4");
    // sweep: read every slot back
    for (int i = 0; i < 64; i++) doRead(addrOf(i), dataOf(i, 0));
    // read then write back to back: turnaround lengthens the write (R7)
    for (int i = 0; i < 16; i++) begin
      doRead(addrOf(i), dataOf(i, 0));
      doWrite(addrOf(i), dataOf(i, 1), E_TURN_SETUP + E_PULSE + E_WREC, "R7");
    end
    for (int i = 0; i < 16; i++) doRead(addrOf(i), dataOf(i, 1));
    // return to idle
    repeat (4) @(negedge clk);
    tally(memCsN && memWeN && memOeN && !memDoutEn && reqReady, "R1", "idle after traffic",
          {memCsN, memWeN, memOeN, memDoutEn, reqReady}, 5'b11101);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule